// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches by consulting three tables of two-bit counters at once. A per-address table gives a bimodal guess. A table indexed by the branch address XOR a global outcome history gives a correlated guess. A third per-address table acts as a referee and picks which of the two guesses is delivered as the final prediction. Fetch presents the low address bits on the predict port and receives, in the same cycle, the final guess, both component guesses and the global index that was used.

When the branch is resolved later, the pipeline returns the address, the two component guesses and the global index it saved at prediction time, together with the real outcome. Both component tables are trained on every resolve. The referee is trained only when the saved guesses disagreed, and then toward the one that was right. The history register takes in the outcome at the same clock edge. All tables are untagged, so branches whose low address bits match share entries.

Top module: `tourney_pred`

## Requirements
- R1: After reset every bimodal and global counter holds weakly-not-taken (01), every referee counter holds 01 and the history is zero, so every address predicts not taken with the bimodal guess selected and pred_gidx_o equal to the low address bits.
- R2: Counters encode 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, and a guess is the counter MSB; pred_taken_o equals the global guess when the referee MSB is 1 and the bimodal guess when it is 0.
- R3: On a valid resolve whose saved guesses differ, the referee entry at res_pc_i moves one step up when the saved global guess equals the outcome and one step down otherwise, saturating at 00 and 11.
- R4: On a valid resolve whose saved guesses are equal, the referee entry is left unchanged.
- R5: Every valid resolve steps the bimodal counter at res_pc_i up on taken and down on not taken, saturating at 11 and 00.
- R6: Every valid resolve steps the global counter at res_gidx_i in the same way; the predict-side global index is the low HIST_W address bits XOR the history and appears on pred_gidx_o.
- R7: A valid resolve shifts the outcome into the history LSB, dropping the oldest bit; the new history is used from the next cycle.
- R8: A prediction in the same cycle as a resolve reads the tables and history as they were before that resolve.
- R9: When res_valid_i is low no counter and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | IDX_W | Low address bits of the branch being predicted |
| pred_taken_o | output | 1 | Final direction guess |
| pred_bim_o | output | 1 | Bimodal guess |
| pred_glb_o | output | 1 | Global-history guess |
| pred_gidx_o | output | HIST_W | Global table index used for this guess |
| res_valid_i | input | 1 | A branch resolves this cycle |
| res_pc_i | input | IDX_W | Low address bits of the resolving branch |
| res_bim_i | input | 1 | Saved bimodal guess |
| res_glb_i | input | 1 | Saved global guess |
| res_gidx_i | input | HIST_W | Saved global table index |
| res_taken_i | input | 1 | Actual outcome, 1 for taken |

## Verification
Prediction and training can fall in the same cycle, including on the very entry being trained and while the history shifts. The bench forces a matching predict and resolve address every third cycle of a long pseudo-random run and in directed referee sweeps, and judges each prediction against a model in the bench that still holds the pre-update state. The model is then advanced at the edge, so a design that forwarded the write or shifted the history early shows up at the next comparison.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // saturating two-bit step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter logic [1:0]  RST_VAL = CTR_WNT
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [1:0]                  rd_ctr_o,
  input  logic                        upd_en_i,
  input  logic [IDX_W-1:0]            upd_idx_i,
  input  logic                        upd_up_i,
  output logic [(1<<IDX_W)-1:0][1:0]  tbl_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][1:0] ctr_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit;
    assign hit = upd_en_i && (upd_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctr_q[e] <= RST_VAL;
      else if (hit) ctr_q[e] <= ctr_step(ctr_q[e], upd_up_i);
    end
  end

  // read before write: same-cycle update is not forwarded
  assign rd_ctr_o = ctr_q[rd_idx_i];
  assign tbl_o    = ctr_q;

endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,  // bimodal / referee index bits
  parameter int unsigned HIST_W = 4   // history length, 2 <= HIST_W <= IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  pred_pc_i,
  output logic              pred_taken_o,
  output logic              pred_bim_o,
  output logic              pred_glb_o,
  output logic [HIST_W-1:0] pred_gidx_o,
  input  logic              res_valid_i,
  input  logic [IDX_W-1:0]  res_pc_i,
  input  logic              res_bim_i,
  input  logic              res_glb_i,
  input  logic [HIST_W-1:0] res_gidx_i,
  input  logic              res_taken_i
);
  localparam int unsigned BIM_N = 1 << IDX_W;
  localparam int unsigned GLB_N = 1 << HIST_W;

  logic [HIST_W-1:0]     ghr;
  logic [HIST_W-1:0]     glb_rd_idx;
  logic [1:0]            bim_ctr, glb_ctr, chs_ctr;
  logic                  chs_en, chs_up;
  logic [BIM_N-1:0][1:0] bim_tbl, chs_tbl;
  logic [GLB_N-1:0][1:0] glb_tbl;

  assign glb_rd_idx = pred_pc_i[HIST_W-1:0] ^ ghr;

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_bim (
    .clk_i, .rst_ni,
    .rd_idx_i  (pred_pc_i),
    .rd_ctr_o  (bim_ctr),
    .upd_en_i  (res_valid_i),
    .upd_idx_i (res_pc_i),
    .upd_up_i  (res_taken_i),
    .tbl_o     (bim_tbl)
  );

  tp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WNT)) u_glb (
    .clk_i, .rst_ni,
    .rd_idx_i  (glb_rd_idx),
    .rd_ctr_o  (glb_ctr),
    .upd_en_i  (res_valid_i),
    .upd_idx_i (res_gidx_i),
    .upd_up_i  (res_taken_i),
    .tbl_o     (glb_tbl)
  );

  // referee trains only on disagreement, toward the component that was right
  assign chs_en = res_valid_i && (res_bim_i != res_glb_i);
  assign chs_up = (res_glb_i == res_taken_i);

  tp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_chs (
    .clk_i, .rst_ni,
    .rd_idx_i  (pred_pc_i),
    .rd_ctr_o  (chs_ctr),
    .upd_en_i  (chs_en),
    .upd_idx_i (res_pc_i),
    .upd_up_i  (chs_up),
    .tbl_o     (chs_tbl)
  );

  tp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk_i, .rst_ni,
    .shift_en_i (res_valid_i),
    .bit_i      (res_taken_i),
    .hist_o     (ghr)
  );

  assign pred_bim_o   = bim_ctr[1];
  assign pred_glb_o   = glb_ctr[1];
  assign pred_taken_o = chs_ctr[1] ? glb_ctr[1] : bim_ctr[1];
  assign pred_gidx_o  = glb_rd_idx;

endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_W = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         res_valid_i,
  input logic [IDX_W-1:0]             res_pc_i,
  input logic                         res_bim_i,
  input logic                         res_glb_i,
  input logic [HIST_W-1:0]            res_gidx_i,
  input logic                         res_taken_i,
  input logic [(1<<IDX_W)-1:0][1:0]   bim_tbl,
  input logic [(1<<IDX_W)-1:0][1:0]   chs_tbl,
  input logic [(1<<HIST_W)-1:0][1:0]  glb_tbl,
  input logic [HIST_W-1:0]            ghr
);

  a_r3_chooser_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_bim_i != res_glb_i && res_glb_i == res_taken_i && chs_tbl[res_pc_i] != 2'b11)
    |=> chs_tbl[$past(res_pc_i)] == $past(chs_tbl[res_pc_i]) + 2'd1);

  a_r3_chooser_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_bim_i != res_glb_i && res_bim_i == res_taken_i && chs_tbl[res_pc_i] != 2'b00)
    |=> chs_tbl[$past(res_pc_i)] == $past(chs_tbl[res_pc_i]) - 2'd1);

  a_r4_chooser_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_bim_i == res_glb_i)
    |=> chs_tbl[$past(res_pc_i)] == $past(chs_tbl[res_pc_i]));

  a_r5_bim_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i && bim_tbl[res_pc_i] == 2'b11)
    |=> bim_tbl[$past(res_pc_i)] == 2'b11);

  a_r6_glb_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_taken_i && glb_tbl[res_gidx_i] == 2'b00)
    |=> glb_tbl[$past(res_gidx_i)] == 2'b00);

  a_r7_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> ghr == {$past(ghr[HIST_W-2:0]), $past(res_taken_i)});

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghr) && $stable(bim_tbl) && $stable(glb_tbl) && $stable(chs_tbl));

endmodule

bind tourney_pred tourney_pred_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_pc_i    (res_pc_i),
  .res_bim_i   (res_bim_i),
  .res_glb_i   (res_glb_i),
  .res_gidx_i  (res_gidx_i),
  .res_taken_i (res_taken_i),
  .bim_tbl     (bim_tbl),
  .chs_tbl     (chs_tbl),
  .glb_tbl     (glb_tbl),
  .ghr         (ghr)
);

// File: tb/test_tourney_pred.sv
`timescale 1ns/1ps
module test_tourney_pred;
  localparam int IW = 4;
  localparam int HW = 4;
  localparam int N  = 1 << IW;
  localparam int GN = 1 << HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [IW-1:0] pred_pc = '0, res_pc = '0;
  logic [HW-1:0] res_gidx = '0, pred_gidx;
  logic res_valid = 0, res_bim = 0, res_glb = 0, res_taken = 0;
  logic pred_taken, pred_bim, pred_glb;

  tourney_pred #(.IDX_W(IW), .HIST_W(HW)) i_tourney_pred (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_pc_i(pred_pc), .pred_taken_o(pred_taken), .pred_bim_o(pred_bim),
    .pred_glb_o(pred_glb), .pred_gidx_o(pred_gidx),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_bim_i(res_bim),
    .res_glb_i(res_glb), .res_gidx_i(res_gidx), .res_taken_i(res_taken)
  );

  int n_cmp = 0, n_bad = 0;
  logic [1:0] m_bim [N];
  logic [1:0] m_chs [N];
  logic [1:0] m_glb [GN];
  logic [HW-1:0] m_ghr;
  logic prev_valid = 0;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare predictions at pred_pc against model (pre-update state)
  task automatic check_pred(input logic collide);
    logic [HW-1:0] gi;
    logic eb, eg, ef;
    gi = pred_pc[HW-1:0] ^ m_ghr;
    eb = m_bim[pred_pc][1];
    eg = m_glb[gi][1];
    ef = m_chs[pred_pc][1] ? eg : eb;
    if (collide) begin
      chk("R8 same-cycle bimodal", pred_bim, eb);
      chk("R8 same-cycle final", pred_taken, ef);
    end
    chk(prev_valid ? "R5 bimodal guess" : "R9 idle bimodal", pred_bim, eb);
    chk(prev_valid ? "R6 global guess" : "R9 idle global", pred_glb, eg);
    chk("R6/R7 global index", pred_gidx, gi);
    chk("R2 R3 R4 final selection", pred_taken, ef);
  endtask

  task automatic step(input logic v, input logic [IW-1:0] rpc, input logic rb,
                      input logic rg, input logic [HW-1:0] rgi, input logic t,
                      input logic [IW-1:0] ppc);
    @(negedge clk);
    res_valid = v; res_pc = rpc; res_bim = rb; res_glb = rg;
    res_gidx = rgi; res_taken = t; pred_pc = ppc;
    #1;
    check_pred(v && (rpc == ppc));
    @(posedge clk);
    if (v) begin
      m_bim[rpc] = sat(m_bim[rpc], t);
      m_glb[rgi] = sat(m_glb[rgi], t);
      if (rb != rg) m_chs[rpc] = sat(m_chs[rpc], rg == t);
      m_ghr = {m_ghr[HW-2:0], t};
    end
    prev_valid = v;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin m_bim[i] = 2'b01; m_chs[i] = 2'b01; end
    for (int i = 0; i < GN; i++) m_glb[i] = 2'b01;
    m_ghr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state at every index
    for (int p = 0; p < N; p++) begin
      @(negedge clk); pred_pc = IW'(p); #1;
      chk("R1 reset bimodal", pred_bim, 0);
      chk("R1 reset global", pred_glb, 0);
      chk("R1 reset final", pred_taken, 0);
      chk("R1 reset gidx", pred_gidx, p % GN);
    end

    // referee sweep per index: drive to 11 via disagreement, hold on agreement, drive to 00
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < 4; k++) step(1, IW'(p), 0, 1, HW'(p), 1, IW'(p));
      for (int k = 0; k < 3; k++) step(1, IW'(p), k[0], k[0], HW'(p), 0, IW'(p));
      for (int k = 0; k < 5; k++) step(1, IW'(p), 1, 0, HW'(p + 3), 1, IW'(p));
      for (int k = 0; k < 5; k++) step(1, IW'(p), 0, 1, HW'(p), 0, IW'(p));
      step(0, IW'(p), 0, 1, HW'(p), 1, IW'(p));
    end

    // saturation runs on every global entry
    for (int g = 0; g < GN; g++) begin
      for (int k = 0; k < 5; k++) step(1, IW'(g), 1, 1, HW'(g), 1, IW'(g ^ 1));
      for (int k = 0; k < 5; k++) step(1, IW'(g), 0, 0, HW'(g), 0, IW'(g));
    end

    // mixed pseudo-random traffic, forced address collision every third cycle
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic v, rb, rg, t;
      logic [IW-1:0] rpc, ppc;
      logic [HW-1:0] rgi;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      v   = lf[0] | lf[1];
      rpc = lf[5:2];
      ppc = (i % 3 == 0) ? rpc : lf[9:6];
      if (lf[10]) begin
        rb  = m_bim[rpc][1];
        rgi = rpc[HW-1:0] ^ m_ghr;
        rg  = m_glb[rgi][1];
      end else begin
        rb  = lf[11];
        rg  = lf[12];
        rgi = lf[15:12];
      end
      t = lf[13] ^ (lf[14] & lf[2]);
      step(v, rpc, rb, rg, rgi, t, ppc);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule